// File: doc/BRIEF.md
# Fan PWM Duty Arbiter

This block drives one fan PWM output. It takes several duty requests and applies the largest of them. The requests are an automatic thermal request on an 8-bit input, a manual override level chosen by a 4-bit code, a sticky processor-hot lock and a spin-up request. It then produces the PWM waveform from a free-running 8-bit counter, with a polarity that software selects.

Software controls the channel through one 8-bit read/write register. A global write-lock input freezes the configuration fields, but it does not freeze the hot-lock status bit, so software can still release a locked fan. Reading the register returns the configuration bits, the live lock status and, in the top nibble, the duty code actually in use, not the code last written.

Top module: `fan_duty_arbiter`

## Requirements
- R1: After reset the register reads 00h, and with the automatic request at 0 and no spin-up the applied duty is 0.
- R2: The register layout is: bit 0 override enable, bit 1 invert, bit 2 hot-lock enable, bit 3 hot-lock status, bits 7:4 override code. A write updates bits 0, 1, 2 and 7:4 only while the write-lock input is low.
- R3: The PWM counter runs freely from 0 to 255. The output is active while the counter is below the applied duty, and it is always active when the duty is 255. Active means high when invert is 0 and low when invert is 1.
- R4: A hot event sets the lock status on the next clock only if the stored lock enable is 1. With lock enable at 0, the status never becomes set.
- R5: While the lock status is 1, the applied duty is 255.
- R6: Writing 0 to bit 3 clears the lock status, even while the write-lock is high. Writing 1 to bit 3 has no effect. A hot event in the same cycle as a clear wins, and the status stays 1.
- R7: Override code n requests a duty of n*17 (code 0 gives 0, code 15 gives 255), but only while override enable is 1.
- R8: The applied duty is the maximum of the automatic request, the override request, the lock request and the spin-up request.
- R9: Read bits 7:4 return floor(applied duty / 17), and return 0 while spin-up is requested.
- R10: A spin-up request forces an applied duty of 255 for as long as it is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data (live) |
| wlock | input | 1 | Global write-lock for configuration fields |
| hot_evt | input | 1 | Processor-hot event |
| spinup | input | 1 | Spin-up interval request |
| auto_duty | input | 8 | Automatic thermal duty request |
| duty_o | output | 8 | Duty currently applied |
| pwm_out | output | 1 | PWM waveform |

## Verification
The bench builds the block with its default widths: an 8-bit duty and a 4-bit code. At that size every combination of override enable, override code and automatic request (8192 cases) can be swept, and the applied duty and readback code are compared against max and divide-by-17 arithmetic. Counting output-high cycles over a full 256-cycle counter period makes the exact duty and polarity observable. Directed sequences cover the lock's enable gating, its clear under write-lock and the collision between a hot event and a clear.

// File: rtl/fda_pkg.sv
package fda_pkg;
  localparam int DUTY_W = 8;
  localparam int CODE_W = 4;
  localparam int FULL   = (1 << DUTY_W) - 1;
  localparam int CMAX   = (1 << CODE_W) - 1;
  localparam int NREQ   = 4;

  function automatic logic [DUTY_W-1:0] code_to_duty(input logic [CODE_W-1:0] c);
    return DUTY_W'((int'(c) * FULL) / CMAX);
  endfunction

  function automatic logic [CODE_W-1:0] duty_to_code(input logic [DUTY_W-1:0] d);
    return CODE_W'((int'(d) * CMAX) / FULL);
  endfunction
endpackage

// File: rtl/fda_regs.sv
module fda_regs
  import fda_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CODE_W+3:0] wr_data,
  input  logic              wlock,
  input  logic              hot_evt,
  output logic              ovr_en,
  output logic              inv,
  output logic              lock_en,
  output logic              locked,
  output logic [CODE_W-1:0] code,
  output logic              lock_set_ev,
  output logic              lock_clr_ev
);
  logic cfg_wr;

  assign cfg_wr      = wr_en & ~wlock;
  assign lock_set_ev = hot_evt & lock_en;
  assign lock_clr_ev = wr_en & ~wr_data[3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_en  <= 1'b0;
      inv     <= 1'b0;
      lock_en <= 1'b0;
      code    <= '0;
    end else if (cfg_wr) begin
      ovr_en  <= wr_data[0];
      inv     <= wr_data[1];
      lock_en <= wr_data[2];
      code    <= wr_data[CODE_W+3:4];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           locked <= 1'b0;
    else if (lock_set_ev) locked <= 1'b1;
    else if (lock_clr_ev) locked <= 1'b0;
  end
endmodule

// File: rtl/fda_arbiter.sv
module fda_arbiter
  import fda_pkg::*;
(
  input  logic [DUTY_W-1:0] auto_duty,
  input  logic              ovr_en,
  input  logic [CODE_W-1:0] code,
  input  logic              locked,
  input  logic              spinup,
  output logic [DUTY_W-1:0] duty
);
  logic [DUTY_W-1:0] req [NREQ];

  assign req[0] = auto_duty;
  assign req[1] = ovr_en ? code_to_duty(code) : '0;
  assign req[2] = locked ? DUTY_W'(FULL) : '0;
  assign req[3] = spinup ? DUTY_W'(FULL) : '0;

  always_comb begin
    duty = '0;
    for (int i = 0; i < NREQ; i++)
      if (req[i] > duty) duty = req[i];
  end
endmodule

// File: rtl/fda_pwm.sv
module fda_pwm
  import fda_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DUTY_W-1:0] duty,
  input  logic              inv,
  output logic              pwm_out
);
  logic [DUTY_W-1:0] cnt;
  logic              active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + 1'b1;
  end

  assign active  = (duty == DUTY_W'(FULL)) || (cnt < duty);
  assign pwm_out = active ^ inv;
endmodule

// File: rtl/fan_duty_arbiter.sv
module fan_duty_arbiter
  import fda_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CODE_W+3:0] wr_data,
  output logic [CODE_W+3:0] rd_data,
  input  logic              wlock,
  input  logic              hot_evt,
  input  logic              spinup,
  input  logic [DUTY_W-1:0] auto_duty,
  output logic [DUTY_W-1:0] duty_o,
  output logic              pwm_out
);
  logic              ovr_en, inv, lock_en, locked;
  logic              lock_set_ev, lock_clr_ev;
  logic [CODE_W-1:0] code;
  logic [CODE_W-1:0] live_code;

  fda_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wlock(wlock), .hot_evt(hot_evt), .ovr_en(ovr_en), .inv(inv),
    .lock_en(lock_en), .locked(locked), .code(code),
    .lock_set_ev(lock_set_ev), .lock_clr_ev(lock_clr_ev)
  );

  fda_arbiter u_arb (
    .auto_duty(auto_duty), .ovr_en(ovr_en), .code(code),
    .locked(locked), .spinup(spinup), .duty(duty_o)
  );

  fda_pwm u_pwm (
    .clk(clk), .rst_n(rst_n), .duty(duty_o), .inv(inv), .pwm_out(pwm_out)
  );

  assign live_code = spinup ? '0 : duty_to_code(duty_o);
  assign rd_data   = {live_code, locked, lock_en, inv, ovr_en};
endmodule

// File: rtl/fda_checker.sv
module fda_checker
  import fda_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [CODE_W+3:0] wr_data,
  input logic [CODE_W+3:0] rd_data,
  input logic              hot_evt,
  input logic              spinup,
  input logic [DUTY_W-1:0] auto_duty,
  input logic [DUTY_W-1:0] duty_o,
  input logic              pwm_out,
  input logic              locked,
  input logic              lock_en
);
  // R5
  a_r5_lock_full: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> duty_o == DUTY_W'(FULL));
  // R4
  a_r4_no_set_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_en && !locked) |=> !locked);
  // R6
  a_r6_clear_wins_alone: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[3] && !(hot_evt && lock_en)) |=> !locked);
  // R6
  a_r6_hot_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (hot_evt && lock_en) |=> locked);
  // R9
  a_r9_spin_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    spinup |-> rd_data[CODE_W+3:4] == '0);
  // R8
  a_r8_not_below_auto: assert property (@(posedge clk) disable iff (!rst_n)
    duty_o >= auto_duty);
  // R3
  a_r3_full_steady: assert property (@(posedge clk) disable iff (!rst_n)
    duty_o == DUTY_W'(FULL) |-> pwm_out == !rd_data[1]);
  // R10
  a_r10_spin_full: assert property (@(posedge clk) disable iff (!rst_n)
    spinup |-> duty_o == DUTY_W'(FULL));
endmodule

bind fan_duty_arbiter fda_checker u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .hot_evt(hot_evt), .spinup(spinup),
  .auto_duty(auto_duty), .duty_o(duty_o), .pwm_out(pwm_out),
  .locked(locked), .lock_en(lock_en)
);

// File: tb/sim_fan_duty_arbiter.sv
`timescale 1ns/1ps
module sim_fan_duty_arbiter;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       wr_en = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic       wlock = 0;
  logic       hot_evt = 0;
  logic       spinup = 0;
  logic [7:0] auto_duty = 0;
  logic [7:0] duty_o;
  logic       pwm_out;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  fan_duty_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .wlock(wlock), .hot_evt(hot_evt), .spinup(spinup),
    .auto_duty(auto_duty), .duty_o(duty_o), .pwm_out(pwm_out)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    wr_data = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
    #2;
  endtask

  task automatic hot_clear(input logic h, input logic clr);
    @(negedge clk);
    hot_evt = h; wr_en = clr; wr_data = 8'h04;
    @(negedge clk);
    hot_evt = 0; wr_en = 0;
    #2;
  endtask

  function automatic int exp_high(input int d, input bit iv);
    int n;
    n = (d == 255) ? 256 : d;
    return iv ? 256 - n : n;
  endfunction

  task automatic pwm_measure(input int d, input bit iv);
    int hi;
    hi = 0;
    for (int k = 0; k < 256; k++) begin
      @(negedge clk);
      #1;
      if (pwm_out) hi++;
    end
    check(iv ? "R3 inverted" : "R3 normal", hi, exp_high(d, iv));
  endtask

  initial begin
    int duties [6] = '{0, 1, 17, 128, 254, 255};
    int e;
    repeat (3) @(negedge clk);
    #2;
    check("R1 reg", rd_data, 0);
    check("R1 duty", duty_o, 0);
    rst_n = 1;
    @(negedge clk); #2;
    check("R1 after release", rd_data, 0);

    // R7 R8 R9: exhaustive sweep
    for (int en = 0; en < 2; en++)
      for (int c = 0; c < 16; c++) begin
        wr(8'((c << 4) | en));
        check("R2 cfg bits", rd_data[0], en);
        for (int a = 0; a < 256; a++) begin
          @(negedge clk);
          auto_duty = 8'(a);
          #2;
          e = (en != 0 && c * 17 > a) ? c * 17 : a;
          check("R8 max", duty_o, e);
          check("R9 readback", rd_data[7:4], e / 17);
        end
      end

    // R3: PWM shape and polarity
    wr(8'h00);
    for (int iv = 0; iv < 2; iv++) begin
      wr(8'(iv << 1));
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        auto_duty = 8'(duties[i]);
        pwm_measure(duties[i], iv[0]);
      end
    end
    @(negedge clk); auto_duty = 0;
    wr(8'h00);

    // R10 spin-up
    @(negedge clk); spinup = 1; auto_duty = 8'd40; #2;
    check("R10 spin duty", duty_o, 255);
    check("R9 spin code", rd_data[7:4], 0);
    @(negedge clk); spinup = 0; #2;
    check("R10 spin released", duty_o, 40);
    @(negedge clk); auto_duty = 0;

    // R2 write-lock blocks config
    wr(8'h51);
    @(negedge clk); wlock = 1;
    wr(8'hA6);
    check("R2 wlock holds cfg", rd_data[3:0], 4'h1);
    check("R2 wlock holds code", duty_o, 85);
    @(negedge clk); wlock = 0;
    wr(8'h00);

    // R4 hot without enable
    hot_clear(1, 0);
    check("R4 unarmed", rd_data[3], 0);
    check("R4 unarmed duty", duty_o, 0);
    // R4/R5 armed
    wr(8'h04);
    hot_clear(1, 0);
    check("R4 armed", rd_data[3], 1);
    check("R5 lock duty", duty_o, 255);
    check("R9 lock code", rd_data[7:4], 15);
    // R6 writing 1 to status while locked: unchanged
    wr(8'h0C);
    check("R6 write one keeps", rd_data[3], 1);
    // R6 hot and clear collide
    hot_clear(1, 1);
    check("R6 hot wins", rd_data[3], 1);
    // R6 clear under write-lock
    @(negedge clk); wlock = 1;
    wr(8'hF0);
    check("R6 clear under wlock", rd_data[3], 0);
    check("R6 cfg untouched", rd_data[2:0], 3'b100);
    check("R6 duty back", duty_o, 0);
    // R6 writing 1 when clear does not set
    wr(8'h0C);
    check("R6 write one no set", rd_data[3], 0);
    @(negedge clk); wlock = 0;

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule